// File: doc/BRIEF.md
# Gated Transition Counter

This block counts level changes on one asynchronous digital input, but only while a timed gate window is open. A one-cycle start request opens the window and, at that moment, captures a mode code that says which transitions count: low-to-high only, high-to-low only, both, or none. It also captures a length in clock cycles. The input is brought into the clock domain through a synchronizer chain. Transitions are found by comparing two successive synchronized samples.

When the window closes, the block raises a one-cycle done strobe. On that same cycle the count output carries its final value. The count and a sticky overflow flag then hold until the next window opens. The count saturates at its all-ones value rather than wrapping. A start request made while a window is open has no effect. The whole counter is an elaboration-time option, and it is off by default. When it is off, the outputs stay at zero.

Top module: `gate_edge_counter`

## Requirements
- R1: After reset, `count`, `ovf`, `done` and `busy` are all 0.
- R2: A `start` sampled high while `busy` is low makes `busy` 1 on the next cycle, and in that same cycle `count` and `ovf` read 0.
- R3: Once opened, `busy` stays high for max(`dur`,1) cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again, and `count`/`ovf` hold their final values in that cycle.
- R4: With mode code 2'b01 latched, only low-to-high transitions of `sig_in` increment the count.
- R5: With mode code 2'b10 latched, only high-to-low transitions increment the count.
- R6: Mode code 2'b11 counts every transition. Mode code 2'b00 runs the window but counts nothing.
- R7: Number the rising clock edges so that edge 0 is the one that accepts `start`. A transition first sampled on edge s is counted only if s+2 lies between 1 and `dur`. Transitions sampled later are not counted.
- R8: A `start` sampled while `busy` is high is ignored. Its `mode` and `dur` do not change the running window, its length or its result.
- R9: When the count would exceed 2^CNT_W-1, it holds at 2^CNT_W-1 and `ovf` goes to 1. `ovf` stays 1 until the next window opens.
- R10: While no window is open, `count` and `ovf` keep their last values whatever `sig_in` does.
- R11: With `COUNTER_EN` = 0 (the default), `busy`, `done`, `ovf` and `count` stay 0 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sig_in | input | 1 | Asynchronous digital input being counted |
| mode | input | 2 | Transition select, latched at window open (01 rise, 10 fall, 11 both, 00 none) |
| dur | input | DUR_W | Window length in clock cycles, latched at window open (0 acts as 1) |
| start | input | 1 | One-cycle request to open a window |
| count | output | CNT_W | Saturating transition count |
| ovf | output | 1 | Sticky saturation flag for the current or last window |
| done | output | 1 | One-cycle strobe when the window closes |
| busy | output | 1 | Window open |

## Verification
Two events can land on the same clock edge: the window closing and the counting of a transition. The bench checks this by placing one transition so that its synchronized edge reaches the counter on the very edge where `busy` falls, and a second transition one cycle later. The expected result counts the first and not the second, and that result must already be on `count` in the cycle where `done` is high. The bench also sends a second start request while a window is open, with a different mode, to show that it cannot restart or alter the running window.

// File: rtl/gec_pkg.sv
package gec_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/gec_sync.sv
module gec_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      genvar i;
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/gec_window.sv
module gec_window
   import gec_pkg::*;
#(
   parameter int DUR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DUR_W-1:0] dur,
   input  logic [1:0]       mode_in,
   output logic             busy,
   output logic             done,
   output logic             launch,
   output edge_sel_e        mode_q
);
   logic [DUR_W-1:0] remain;

   assign launch = start & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         remain <= '0;
         mode_q <= EDGE_NONE;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (remain <= DUR_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               remain <= remain - DUR_W'(1);
            end
         end else if (start) begin
            busy   <= 1'b1;
            remain <= dur;
            mode_q <= edge_sel_e'(mode_in);
         end
      end
   end
endmodule

// File: rtl/gec_accum.sv
module gec_accum #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (inc) begin
         if (count == CNT_MAX) ovf   <= 1'b1;
         else                  count <= count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/gate_edge_counter.sv
module gate_edge_counter
   import gec_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DUR_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter bit COUNTER_EN  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sig_in,
   input  logic [1:0]       mode,
   input  logic [DUR_W-1:0] dur,
   input  logic             start,
   output logic [CNT_W-1:0] count,
   output logic             ovf,
   output logic             done,
   output logic             busy
);
   if (CNT_W < 2)       begin : g_bad_cnt  $error("CNT_W must be at least 2");       end
   if (DUR_W < 2)       begin : g_bad_dur  $error("DUR_W must be at least 2");       end
   if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end

   generate
      if (COUNTER_EN) begin : g_on
         logic      rise, fall, launch, inc;
         edge_sel_e sel;
         logic [1:0] sel_bits;

         gec_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .din(sig_in), .rise(rise), .fall(fall)
         );

         gec_window #(.DUR_W(DUR_W)) u_win (
            .clk(clk), .rst_n(rst_n), .start(start), .dur(dur), .mode_in(mode),
            .busy(busy), .done(done), .launch(launch), .mode_q(sel)
         );

         assign sel_bits = sel;
         assign inc = busy & ((sel_bits[0] & rise) | (sel_bits[1] & fall));

         gec_accum #(.CNT_W(CNT_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .clr(launch), .inc(inc),
            .count(count), .ovf(ovf)
         );
      end else begin : g_off
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, sig_in, mode, dur, start};
         assign count = '0;
         assign ovf   = 1'b0;
         assign done  = 1'b0;
         assign busy  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/gate_edge_counter_chk.sv
module gate_edge_counter_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [CNT_W-1:0] count,
   input logic             ovf,
   input logic             done,
   input logic             busy
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   AST_CLEAR_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (count == '0 && !ovf)); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R3
   AST_DONE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R3
   AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done)); // R8
   AST_SAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> count == CNT_MAX); // R9
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (count == $past(count) || count == $past(count) + CNT_W'(1))); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(count) && $stable(ovf))); // R10
endmodule

bind gate_edge_counter gate_edge_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .count(count),
   .ovf(ovf), .done(done), .busy(busy)
);

// File: tb/gate_edge_counter_tb.sv
module gate_edge_counter_tb;
   localparam int CNT_W = 4;
   localparam int DUR_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sig_in = 1'b0;
   logic [1:0]       mode = 2'b00;
   logic [DUR_W-1:0] dur = '0;
   logic             start = 1'b0;
   logic [CNT_W-1:0] count, count_off;
   logic             ovf, done, busy, ovf_off, done_off, busy_off;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   gate_edge_counter #(.CNT_W(CNT_W), .DUR_W(DUR_W), .COUNTER_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .mode(mode), .dur(dur),
      .start(start), .count(count), .ovf(ovf), .done(done), .busy(busy)
   );

   gate_edge_counter #(.CNT_W(CNT_W), .DUR_W(DUR_W)) u_off (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .mode(mode), .dur(dur),
      .start(start), .count(count_off), .ovf(ovf_off), .done(done_off), .busy(busy_off)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Open one window and walk it negedge by negedge.
   task automatic run_gate(input logic [1:0] md, input int d, input logic [63:0] tog,
                           input int restart_at, input logic [1:0] rmode, input string tag);
      int eff = (d < 1) ? 1 : d;
      int exp_cnt = 0;
      int exp_ovf = 0;
      int held;
      @(negedge clk);
      mode = md; dur = DUR_W'(d); start = 1'b1;
      for (int j = 0; j <= eff + 1; j++) begin
         @(negedge clk);
         start = 1'b0;
         if (j == 0) begin
            check({tag, " R2 busy at open"}, int'(busy), 1);
            check({tag, " R2 count cleared"}, int'(count), 0);
            check({tag, " R2 ovf cleared"}, int'(ovf), 0);
         end
         if (j == eff - 1 && eff > 1) check({tag, " R3 still open"}, int'(busy), 1);
         if (j == eff) begin
            check({tag, " R3 done strobe"}, int'(done), 1);
            check({tag, " R3 busy low"}, int'(busy), 0);
            check({tag, " R4/R5/R6/R7/R8 count"}, int'(count), exp_cnt);
            check({tag, " R9 ovf"}, int'(ovf), exp_ovf);
         end
         if (j == eff + 1) check({tag, " R3 done one cycle"}, int'(done), 0);
         if (j < 64 && tog[j]) begin
            if (j <= eff - 3) begin
               // rising when sig_in currently 0
               if ((md[0] && !sig_in) || (md[1] && sig_in)) begin
                  if (exp_cnt == (1 << CNT_W) - 1) exp_ovf = 1;
                  else exp_cnt++;
               end
            end
            sig_in = ~sig_in;
         end
         if (j == restart_at) begin
            start = 1'b1; mode = rmode; dur = DUR_W'(3);
         end
      end
      // idle: toggle input, results must hold
      held = int'(count);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         sig_in = ~sig_in;
      end
      repeat (4) @(negedge clk);
      check({tag, " R10 count held"}, int'(count), held);
      check({tag, " R10 ovf held"}, int'(ovf), exp_ovf);
      check({tag, " R11 disabled outputs"},
            int'({busy_off, done_off, ovf_off, count_off}), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 count", int'(count), 0);
      check("R1 ovf", int'(ovf), 0);
      check("R1 done", int'(done), 0);
      check("R1 busy", int'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      run_gate(2'b01, 30, 64'h0000_0000_0249_2492, -1, 2'b00, "rise");
      run_gate(2'b10, 30, 64'h0000_0000_0249_2492, -1, 2'b00, "fall");
      run_gate(2'b11, 30, 64'h0000_0000_0249_2492, -1, 2'b00, "both");
      run_gate(2'b00, 20, 64'h0000_0000_0000_5555, -1, 2'b00, "none R6");
      // window edge: toggle at 9 lands on closing edge, 10 is late (R7)
      run_gate(2'b11, 12, 64'h0000_0000_0000_0600, -1, 2'b00, "edge R7");
      // second start mid-window with other mode (R8)
      run_gate(2'b01, 20, 64'h0000_0000_0000_5554, 5, 2'b11, "restart R8");
      // saturation (R9)
      run_gate(2'b11, 60, 64'h00FF_FFFF_FFFF_FFFF, -1, 2'b00, "sat R9");
      // next window clears ovf (R2/R9)
      run_gate(2'b01, 10, 64'h0000_0000_0000_0006, -1, 2'b00, "clear R9");
      // zero length acts as one (R3)
      run_gate(2'b11, 0, 64'h0, -1, 2'b00, "zero R3");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule